// File: doc/BRIEF.md
# Script Branch Condition Unit

This unit decides the outcome of the flow-control instructions of a script engine: jump, call and return. Each cycle it receives the first word of the instruction being executed (the command word), its second word (the operand), the bus phase currently seen on the attached bus, and the script pointer. That pointer already points past the operand. From these inputs it computes, in the same cycle, whether the branch is taken and which pointer execution continues at. When a taken call is executed, it also asks for the return-address holder to be written.

The condition has two parts. A polarity bit in the command word selects whether the jump fires when the condition is true or when it is false. An optional phase test compares an expected phase, encoded in the command word, with the live bus phase. The carry test and the interrupt-on-the-fly option are not supported, and a command that requests either is reported as an error. Targets are either absolute or a signed 24-bit displacement from the pointer. A single registered return address is saved by a taken call and restored by a taken return.

Top module: `branch_cond_unit`

## Requirements
- R1: The kind of instruction is taken from command bits [31:27]. 5'b10000 is a jump, 5'b10001 a call and 5'b10010 a return. Any other value gives taken=0, temp_we=0, cond_err=0 and next_ptr=ptr_in.
- R2: Command bit 19 is the wanted outcome. When command bit 17 is set, the phase result is 1 if command bits [26:24] equal bus_phase and 0 otherwise. When bit 17 is clear, the phase result equals the wanted outcome. A branch is taken exactly when the phase result equals the wanted outcome.
- R3: For a taken jump or call with command bit 23 set, next_ptr is ptr_in plus operand[23:0] sign-extended from bit 23, modulo 2^ADDR_W.
- R4: For a taken jump or call with command bit 23 clear, next_ptr equals the operand.
- R5: When a branch is not taken, next_ptr equals ptr_in (the operand is skipped) and temp_we is 0.
- R6: A taken call with exec_valid high drives temp_we=1. At the next rising clock edge, ret_addr takes the value of ptr_in.
- R7: For a taken return, next_ptr equals ret_addr whatever the operand holds. A return never drives temp_we.
- R8: A jump, call or return with command bit 21 (carry test) or bit 20 (interrupt on the fly) set drives cond_err=1, taken=0, temp_we=0 and next_ptr=ptr_in.
- R9: While rst_n is low, ret_addr is 0.
- R10: ret_addr changes only at a clock edge where temp_we is 1. A taken call presented with exec_valid low leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_valid | input | 1 | Instruction on the inputs is being executed this cycle |
| cmd_word | input | 32 | First instruction word |
| operand | input | ADDR_W | Second instruction word (target or displacement) |
| bus_phase | input | 3 | Current bus phase |
| ptr_in | input | ADDR_W | Script pointer, already past the operand |
| taken | output | 1 | Branch condition satisfied |
| next_ptr | output | ADDR_W | Pointer to continue at |
| temp_we | output | 1 | Return-address holder written at the next edge |
| ret_addr | output | ADDR_W | Saved return address |
| cond_err | output | 1 | Unsupported condition option requested |

## Verification
Random commands mix the three branch kinds with other opcodes. They use both polarities, the phase test on and off, and phases that are forced to match half the time, so the bench can tell the polarity logic apart from the phase compare. Displacements are random 24-bit values, including negative ones and ones that wrap past zero, which separates correct sign extension from zero extension. Call and return sequences show that the holder saves the post-operand pointer and ignores the return's operand. Directed cases cover each unsupported option bit, a call presented without exec_valid, and a return issued before any call.

// File: rtl/branch_unit_pkg.sv
package branch_unit_pkg;
   localparam int unsigned CMD_W     = 32;
   localparam int unsigned PHASE_W   = 3;
   localparam int unsigned KIND_LSB  = 27;
   localparam int unsigned PHASE_LSB = 24;
   localparam int unsigned BIT_REL   = 23;
   localparam int unsigned BIT_CARRY = 21;
   localparam int unsigned BIT_IFLY  = 20;
   localparam int unsigned BIT_WANT  = 19;
   localparam int unsigned BIT_PTEST = 17;

   typedef enum logic [4:0] {
      KIND_JUMP = 5'b10000,
      KIND_CALL = 5'b10001,
      KIND_RET  = 5'b10010
   } br_kind_e;

   typedef struct packed {
      logic               is_jump;
      logic               is_call;
      logic               is_ret;
      logic               use_rel;
      logic               want;
      logic               ptest_en;
      logic               unsup;
      logic [PHASE_W-1:0] exp_phase;
   } br_dec_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
   import branch_unit_pkg::*;
(
   input  logic [CMD_W-1:0] cmd,
   output br_dec_t          dec
);
   logic [4:0] kind;
   logic       unused_cmd_bits;

   assign kind            = cmd[KIND_LSB +: 5];
   assign unused_cmd_bits = ^{cmd[22], cmd[18], cmd[16:0]};

   always_comb begin
      dec           = '0;
      dec.is_jump   = (kind == KIND_JUMP);
      dec.is_call   = (kind == KIND_CALL);
      dec.is_ret    = (kind == KIND_RET);
      dec.use_rel   = cmd[BIT_REL];
      dec.want      = cmd[BIT_WANT];
      dec.ptest_en  = cmd[BIT_PTEST];
      dec.unsup     = cmd[BIT_CARRY] | cmd[BIT_IFLY];
      dec.exp_phase = cmd[PHASE_LSB +: PHASE_W];
   end
endmodule

// File: rtl/br_cond.sv
module br_cond
   import branch_unit_pkg::*;
(
   input  br_dec_t              dec,
   input  logic [PHASE_W-1:0]   phase,
   output logic                 pass
);
   logic phase_res;
   logic data_res;

   always_comb begin
      phase_res = dec.ptest_en ? (dec.exp_phase == phase) : dec.want;
      data_res  = dec.want;
      pass      = (phase_res == dec.want) && (data_res == dec.want);
   end
endmodule

// File: rtl/br_target.sv
module br_target #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFFS_W = 24,
   parameter bit          REL_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] operand,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              use_rel,
   output logic [ADDR_W-1:0] target
);
   localparam int unsigned EXT_W = ADDR_W - OFFS_W;

   if (ADDR_W < OFFS_W) begin : g_bad_width
      $error("br_target: ADDR_W must be at least OFFS_W");
   end

   if (!REL_EN) begin : g_abs_only
      logic unused_rel;
      assign unused_rel = use_rel ^ (^ptr);
      assign target     = operand;
   end else begin : g_rel
      logic [ADDR_W-1:0] disp;
      if (EXT_W == 0) begin : g_noext
         assign disp = operand;
      end else begin : g_ext
         assign disp = {{EXT_W{operand[OFFS_W-1]}}, operand[OFFS_W-1:0]};
      end
      assign target = use_rel ? (ptr + disp) : operand;
   end
endmodule

// File: rtl/br_ret_reg.sv
module br_ret_reg #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end

   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(d)));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
   import branch_unit_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFFS_W = 24,
   parameter bit          REL_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 exec_valid,
   input  logic [CMD_W-1:0]     cmd_word,
   input  logic [ADDR_W-1:0]    operand,
   input  logic [PHASE_W-1:0]   bus_phase,
   input  logic [ADDR_W-1:0]    ptr_in,
   output logic                 taken,
   output logic [ADDR_W-1:0]    next_ptr,
   output logic                 temp_we,
   output logic [ADDR_W-1:0]    ret_addr,
   output logic                 cond_err
);
   br_dec_t           dec;
   logic              cond_pass;
   logic              is_branch;
   logic [ADDR_W-1:0] tgt;

   br_decode u_dec (.cmd(cmd_word), .dec(dec));

   br_cond u_cond (.dec(dec), .phase(bus_phase), .pass(cond_pass));

   br_target #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .REL_EN(REL_EN)) u_tgt (
      .operand(operand), .ptr(ptr_in), .use_rel(dec.use_rel), .target(tgt));

   br_ret_reg #(.ADDR_W(ADDR_W)) u_ret (
      .clk(clk), .rst_n(rst_n), .we(temp_we), .d(ptr_in), .q(ret_addr));

   always_comb begin
      is_branch = dec.is_jump | dec.is_call | dec.is_ret;
      cond_err  = is_branch & dec.unsup;
      taken     = is_branch & ~dec.unsup & cond_pass;
      temp_we   = exec_valid & taken & dec.is_call;
      if (!taken)          next_ptr = ptr_in;
      else if (dec.is_ret) next_ptr = ret_addr;
      else                 next_ptr = tgt;
   end

   a_r8_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cond_err |-> (!taken && !temp_we));
   a_r5_skip_operand: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |-> (next_ptr == ptr_in && !temp_we));
   a_r7_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && cmd_word[31:27] == KIND_RET) |-> (next_ptr == ret_addr && !temp_we));
   a_r1_other_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_word[31:28] != 4'b1000 && cmd_word[31:27] != KIND_RET)
         |-> (!taken && !cond_err));
endmodule

// File: tb/tb_branch_cond_unit.sv
module tb_branch_cond_unit;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          exec_valid;
   logic [31:0]   cmd_word;
   logic [AW-1:0] operand;
   logic [2:0]    bus_phase;
   logic [AW-1:0] ptr_in;
   logic          taken, temp_we, cond_err;
   logic [AW-1:0] next_ptr, ret_addr;

   int checks = 0;
   int errors = 0;
   logic [AW-1:0] model_ret;
   bit done = 0;

   always #4 clk = ~clk;

   branch_cond_unit dut (
      .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .cmd_word(cmd_word),
      .operand(operand), .bus_phase(bus_phase), .ptr_in(ptr_in),
      .taken(taken), .next_ptr(next_ptr), .temp_we(temp_we),
      .ret_addr(ret_addr), .cond_err(cond_err));

   task automatic chk(input string req, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string classify(input logic [31:0] c, input logic t);
      logic [4:0] k = c[31:27];
      if (k != 5'b10000 && k != 5'b10001 && k != 5'b10010) return "R1";
      if (c[21] | c[20]) return "R8";
      if (!t) return "R5";
      if (k == 5'b10010) return "R7";
      if (k == 5'b10001) return "R6";
      if (c[23]) return "R3";
      return "R4";
   endfunction

   task automatic apply(input logic [31:0] c, input logic [AW-1:0] op,
                        input logic [2:0] ph, input logic [AW-1:0] p,
                        input logic ev, input string tag);
      logic [4:0] k;
      logic br, er, pt, t, w;
      logic [AW-1:0] tg, np;
      string rq;
      @(negedge clk);
      cmd_word = c; operand = op; bus_phase = ph; ptr_in = p; exec_valid = ev;
      k  = c[31:27];
      br = (k == 5'b10000) || (k == 5'b10001) || (k == 5'b10010);
      er = br && (c[21] || c[20]);
      pt = c[17] ? (c[26:24] == ph) : c[19];
      t  = br && !er && (pt == c[19]);
      tg = c[23] ? p + {{8{op[23]}}, op[23:0]} : op;
      np = !t ? p : ((k == 5'b10010) ? model_ret : tg);
      w  = t && (k == 5'b10001) && ev;
      rq = (tag == "") ? classify(c, t) : tag;
      #1;
      chk(rq, "taken", AW'(taken), AW'(t));
      chk(rq, "next_ptr", next_ptr, np);
      chk(rq, "temp_we", AW'(temp_we), AW'(w));
      chk(rq, "cond_err", AW'(cond_err), AW'(er));
      chk("R10", "ret_addr", ret_addr, model_ret);
      @(posedge clk);
      if (w) model_ret = p;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] c;
      logic [AW-1:0] op, p;
      logic [2:0] ph;
      int unsigned r;
      void'($urandom(32'd7421));
      rst_n = 1'b0; exec_valid = 1'b0; cmd_word = '0; operand = '0;
      bus_phase = '0; ptr_in = '0; model_ret = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R9", "ret_addr reset", ret_addr, '0);
      @(negedge clk); rst_n = 1'b1;

      // return before any call: restores reset value, ignores operand (R7)
      apply(32'h9008_0000, 32'hDEAD_BEEF, 3'd0, 32'h100, 1'b1, "R7");
      // absolute jump (R4)
      apply(32'h8008_0000, 32'h0000_4000, 3'd0, 32'h200, 1'b1, "R4");
      // relative negative displacement (R3)
      apply(32'h8088_0000, 32'h00FF_FFF0, 3'd0, 32'h0000_1000, 1'b1, "R3");
      // relative wrap below zero (R3)
      apply(32'h8088_0000, 32'h00FF_FF00, 3'd0, 32'h0000_0010, 1'b1, "R3");
      // phase test match with jump-if-true (R2)
      apply(32'h870A_0000, 32'h0000_0800, 3'd7, 32'h300, 1'b1, "R2");
      // phase mismatch with jump-if-true: not taken (R2)
      apply(32'h870A_0000, 32'h0000_0800, 3'd3, 32'h300, 1'b1, "R2");
      // phase mismatch with jump-if-false: taken (R2)
      apply(32'h8702_0000, 32'h0000_0800, 3'd3, 32'h300, 1'b1, "R2");
      // test disabled with polarity false still taken (R2)
      apply(32'h8000_0000, 32'h0000_0900, 3'd3, 32'h300, 1'b1, "R2");
      // carry test and interrupt-on-the-fly flagged (R8)
      apply(32'h8028_0000, 32'h0000_0A00, 3'd0, 32'h400, 1'b1, "R8");
      apply(32'h8818_0000, 32'h0000_0A00, 3'd0, 32'h404, 1'b1, "R8");
      // call without exec_valid: holder unchanged (R10)
      apply(32'h8808_0000, 32'h0000_5000, 3'd0, 32'h0000_0777, 1'b0, "R10");
      // call with exec_valid then return (R6, R7)
      apply(32'h8808_0000, 32'h0000_5000, 3'd0, 32'h0000_0888, 1'b1, "R6");
      apply(32'h9008_0000, 32'h1234_5678, 3'd0, 32'h0000_5010, 1'b1, "R7");
      // non-branch opcode (R1)
      apply(32'h5808_0000, 32'h0000_6000, 3'd0, 32'h500, 1'b1, "R1");

      for (int i = 0; i < 3000; i++) begin
         r = $urandom % 8;
         c = $urandom;
         case (r)
            0, 1, 2: c[31:27] = 5'b10000;
            3, 4:    c[31:27] = 5'b10001;
            5, 6:    c[31:27] = 5'b10010;
            default: ;
         endcase
         if (($urandom % 8) != 0) begin c[21] = 1'b0; c[20] = 1'b0; end
         op = $urandom; p = $urandom; p[1:0] = 2'b00;
         ph = (($urandom % 2) == 0) ? c[26:24] : 3'($urandom);
         apply(c, op, ph, p, 1'($urandom % 4 != 0), "");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule